// File: doc/BRIEF.md
# Parking Availability Scanned Display

This block drives an eight-digit, common-anode seven-segment display for a car park with two sections: a normal section of up to 20 spaces and an accessible section of up to 5 spaces. It takes the current free-space count of each section and scans the digits one at a time. Each digit is lit long enough, and often enough, that the eye sees all eight at once.

The normal count appears as two decimal digits on positions 1 (tens) and 0 (units). The accessible count appears as one digit on position 4. Availability letters appear beside the counts: "A" on position 3 while normal spaces remain, and "HA" on positions 7 and 6 while accessible spaces remain. Positions 2 and 5 stay dark. The digit and its pattern come from one register stage, so the pattern on the segment bus always belongs to the digit that is selected.

Top module: `park_disp_mux`

## Requirements
- R1: Outside reset, exactly one of the eight active-low anode lines is low in every cycle.
- R2: A synchronous reset clears the refresh prescaler and the digit index. In the cycle after a reset edge, all anodes and all segments are high. After reset is released, digit 0 is the first digit lit.
- R3: Digits are lit in the order 0, 1, …, 7 and then back to 0. Each digit stays lit for DIV consecutive cycles. Anode k is active when an_n equals ~(1<<k).
- R4: While the normal count is 0 to 20, digit 1 shows its tens digit, including a leading 0, and digit 0 shows its units digit.
- R5: While the accessible count is 0 to 5, digit 4 shows it as one decimal digit.
- R6: Digit 3 shows "A" (8'b10001000) whenever the normal count is nonzero. It is blank (8'hFF) when that count is zero.
- R7: Whenever the accessible count is nonzero, digit 7 shows "H" (8'b10001001) and digit 6 shows "A". Both are blank when that count is zero.
- R8: Digits 2 and 5 are always blank, and the decimal point (bit 7) is always high.
- R9: A normal count above 20 blanks digits 1 and 0. An accessible count above 5 blanks digit 4. The letters still follow whether the count is nonzero.
- R10: Segments are active low in bit order {dp,g,f,e,d,c,b,a}. The decimal digits 0 to 9 are C0, F9, A4, B0, 99, 92, 82, F8, 80 and 90 in hex.
- R11: A change of either count appears on the matching digit the next time that digit is scanned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| norm_free | input | 5 | Free spaces in the normal section |
| hand_free | input | 3 | Free spaces in the accessible section |
| seg_n | output | 8 | Active-low segments {dp,g,f,e,d,c,b,a} |
| an_n | output | 8 | Active-low digit select |

## Verification
The assertions assume the reset is held for at least one clock at start-up. They also assume the count inputs change only on clock edges, so a count sampled one cycle earlier is the one that built the current pattern. The bench changes the counts only at falling edges and holds each pair for more than a full scan before it compares any digit. It also applies out-of-range codes on purpose, so that the blanking of invalid counts is exercised alongside the valid ones.

// File: rtl/park_disp_mux.sv
module park_disp_mux #(
  parameter int DIV  = 100000,
  parameter int NMAX = 20,
  parameter int HMAX = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [4:0] norm_free,
  input  logic [2:0] hand_free,
  output logic [7:0] seg_n,
  output logic [7:0] an_n
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [7:0] BLANK = 8'hFF;
  localparam logic [7:0] GL_A  = 8'b10001000;
  localparam logic [7:0] GL_H  = 8'b10001001;

  logic [CW-1:0] pre;
  logic [2:0]    idx;
  logic [3:0]    tens, units;
  logic [7:0]    glyph_sel;
  logic [4:0]    base;

  wire tick    = (pre == CW'(DIV - 1));
  wire norm_ok = (32'(norm_free) <= NMAX);
  wire hand_ok = (32'(hand_free) <= HMAX);

  function automatic logic [7:0] dec7(input logic [3:0] v);
    case (v)
      4'd0: dec7 = 8'hC0;
      4'd1: dec7 = 8'hF9;
      4'd2: dec7 = 8'hA4;
      4'd3: dec7 = 8'hB0;
      4'd4: dec7 = 8'h99;
      4'd5: dec7 = 8'h92;
      4'd6: dec7 = 8'h82;
      4'd7: dec7 = 8'hF8;
      4'd8: dec7 = 8'h80;
      4'd9: dec7 = 8'h90;
      default: dec7 = BLANK;
    endcase
  endfunction

  always_comb begin
    if (norm_free >= 5'd20) begin
      tens = 4'd2; base = 5'd20;
    end else if (norm_free >= 5'd10) begin
      tens = 4'd1; base = 5'd10;
    end else begin
      tens = 4'd0; base = 5'd0;
    end
    units = 4'(norm_free - base);
  end

  always_comb begin
    case (idx)
      3'd0: glyph_sel = norm_ok ? dec7(units) : BLANK;
      3'd1: glyph_sel = norm_ok ? dec7(tens) : BLANK;
      3'd3: glyph_sel = (norm_free != 5'd0) ? GL_A : BLANK;
      3'd4: glyph_sel = hand_ok ? dec7({1'b0, hand_free}) : BLANK;
      3'd6: glyph_sel = (hand_free != 3'd0) ? GL_A : BLANK;
      3'd7: glyph_sel = (hand_free != 3'd0) ? GL_H : BLANK;
      default: glyph_sel = BLANK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      idx <= '0;
    end else if (tick) begin
      pre <= '0;
      idx <= idx + 3'd1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      an_n  <= BLANK;
      seg_n <= BLANK;
    end else begin
      an_n  <= ~(8'b1 << idx);
      seg_n <= glyph_sel;
    end
  end
endmodule

// File: rtl/park_disp_chk.sv
module park_disp_chk (
  input logic       clk,
  input logic       rst,
  input logic [4:0] norm_free,
  input logic [2:0] hand_free,
  input logic [7:0] seg_n,
  input logic [7:0] an_n
);
  logic [7:0] prev_an;
  always_ff @(posedge clk) prev_an <= an_n;

  a_r1_one_anode: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(~an_n) == 1);

  a_r2_reset_dark: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (an_n == 8'hFF && seg_n == 8'hFF));

  a_r3_scan_order: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && prev_an != 8'hFF && an_n != prev_an)
      |-> an_n == {prev_an[6:0], prev_an[7]});

  a_r8_dp_off: assert property (@(posedge clk) disable iff (rst)
    seg_n[7] == 1'b1);

  a_r8_gap_blank: assert property (@(posedge clk) disable iff (rst)
    (an_n == 8'hFB || an_n == 8'hDF) |-> seg_n == 8'hFF);

  a_r7_hand_letters_off: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (an_n == 8'h7F || an_n == 8'hBF) && $past(hand_free) == 3'd0)
      |-> seg_n == 8'hFF);

  a_r6_norm_letter: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && an_n == 8'hF7)
      |-> seg_n == (($past(norm_free) != 5'd0) ? 8'b10001000 : 8'hFF));
endmodule

bind park_disp_mux park_disp_chk u_chk (.*);

// File: tb/sim_park_disp_mux.sv
module sim_park_disp_mux;
  localparam int DIV = 4;
  localparam int NV  = 10;
  localparam logic [7:0] vecs [NV] = '{
    {5'd20, 3'd5}, {5'd0, 3'd0}, {5'd9, 3'd3}, {5'd10, 3'd1}, {5'd15, 3'd0},
    {5'd0, 3'd4}, {5'd19, 3'd2}, {5'd21, 3'd2}, {5'd31, 3'd7}, {5'd1, 3'd6}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] norm_free = '0;
  logic [2:0] hand_free = '0;
  logic [7:0] seg_n, an_n;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  park_disp_mux #(.DIV(DIV)) u0 (.clk, .rst, .norm_free, .hand_free, .seg_n, .an_n);

  function automatic logic [7:0] digit_pat(input int v);
    logic [7:0] t [10] = '{8'hC0, 8'hF9, 8'hA4, 8'hB0, 8'h99,
                           8'h92, 8'h82, 8'hF8, 8'h80, 8'h90};
    return t[v];
  endfunction

  function automatic logic [7:0] expect_seg(input int d, input int n, input int h);
    case (d)
      0: return (n <= 20) ? digit_pat(n % 10) : 8'hFF;
      1: return (n <= 20) ? digit_pat(n / 10) : 8'hFF;
      3: return (n != 0) ? 8'b10001000 : 8'hFF;
      4: return (h <= 5) ? digit_pat(h) : 8'hFF;
      6: return (h != 0) ? 8'b10001000 : 8'hFF;
      7: return (h != 0) ? 8'b10001001 : 8'hFF;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(input int d, input int n, input int h);
    if ((d <= 1 && n > 20) || (d == 4 && h > 5)) return "R9";
    case (d)
      0, 1: return "R4";
      3: return "R6";
      4: return "R5";
      6, 7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic wait_digit(input int d);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (an_n == ~(8'b1 << d)) return;
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    wait (cycles > 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(an_n == 8'hFF, "R2 anodes in reset", an_n, 8'hFF);
    check(seg_n == 8'hFF, "R2 segments in reset", seg_n, 8'hFF);
    rst = 1'b0;
    @(negedge clk);
    check(an_n == 8'hFE, "R2 first digit after reset", an_n, 8'hFE);
    repeat (3) @(negedge clk);
    check(an_n == 8'hFE, "R3 dwell end of digit 0", an_n, 8'hFE);
    @(negedge clk);
    check(an_n == 8'hFD, "R3 step to digit 1", an_n, 8'hFD);

    for (int v = 0; v < NV; v++) begin
      int n, h;
      n = int'(vecs[v][7:3]);
      h = int'(vecs[v][2:0]);
      norm_free = vecs[v][7:3];
      hand_free = vecs[v][2:0];
      repeat (8 * DIV + 2) @(negedge clk);
      for (int d = 0; d < 8; d++) begin
        logic [7:0] e;
        wait_digit(d);
        e = expect_seg(d, n, h);
        check(seg_n == e, tag_for(d, n, h), seg_n, e);
        check($countones(~an_n) == 1, "R1 single anode", an_n, ~(8'b1 << d));
      end
    end

    begin
      logic [7:0] a0;
      int run;
      wait_digit(2);
      a0 = an_n;
      run = 1;
      @(negedge clk);
      while (an_n == a0) begin run++; @(negedge clk); end
      check(run == DIV, "R3 dwell length", 8'(run), 8'(DIV));
      check(an_n == 8'hF7, "R3 order 2 to 3", an_n, 8'hF7);
      check(seg_n[7] == 1'b1, "R8 decimal point", seg_n, 8'h80);
    end

    norm_free = 5'd7; hand_free = 3'd2;
    repeat (8 * DIV + 2) @(negedge clk);
    wait_digit(7);
    check(seg_n == 8'b10001001, "R10 H glyph", seg_n, 8'b10001001);
    norm_free = 5'd0;
    wait_digit(0); wait_digit(1); wait_digit(3);
    check(seg_n == 8'hFF, "R11 letter drops on zero", seg_n, 8'hFF);
    wait_digit(0);
    check(seg_n == 8'hC0, "R11 units updates", seg_n, 8'hC0);
    hand_free = 3'd0;
    wait_digit(5); wait_digit(6);
    check(seg_n == 8'hFF, "R7 A blank at zero", seg_n, 8'hFF);
    wait_digit(4);
    check(seg_n == 8'hC0, "R5 zero accessible", seg_n, 8'hC0);

    rst = 1'b1;
    @(negedge clk);
    check(an_n == 8'hFF, "R2 mid-scan reset", an_n, 8'hFF);
    rst = 1'b0;
    @(negedge clk);
    check(an_n == 8'hFE, "R2 restart at digit 0", an_n, 8'hFE);
    finish_run();
  end
endmodule